// File: doc/BRIEF.md
# Supply Supervisor with Brown-out Reset and Power-Warning Interrupt

This block watches two comparator outputs that report the supply rail against two thresholds. One threshold is a warning level and the other is a reset level. When the rail sinks under the warning level, the supervisor latches a sticky status flag and, if enabled, emits a one-cycle interrupt request. When the rail sinks under the reset level, the supervisor asserts the processor's internal reset. It holds that reset until the rail has recovered and a stabilisation count of oscillator cycles has run to completion. The same release sequence follows a cold start of the supervisor itself, and a cold start also leaves a power-on flag set for software to inspect.

Software reaches the flags and two enable bits through one 8-bit register. The flags are cleared by writing 1 to them. One enable bit gates the interrupt request. The other decides whether the reference and the comparators stay powered in a low-consumption mode while the processor sleeps, or are switched off. While the monitor is switched off, both comparator inputs are disregarded, so they cannot disturb the flags, the interrupt or the reset.

Top module: `pwrsup`

## Requirements
- R1: While `rst` is high and immediately after it, `cpu_rst` is 1, `warn_irq` is 0, `mon_en` is 1, `mon_lp` is 0 and `reg_rdata` reads 8'h02: the power-on flag is in bit 1 and every other bit is 0.
- R2: Once the synchronised warning input is high with the monitor on, the power-warning flag (`reg_rdata` bit 0) reads 1 after the third clock edge from the input change. It stays 1 after the input returns low, until software clears it.
- R3: Writing 1 to bit 0 clears the power-warning flag, and writing 0 to bit 0 leaves it unchanged. If the warning input is still high when the write lands, the hardware set wins and the flag stays 1.
- R4: With the interrupt-enable bit (bit 4) at 1, a rise of the synchronised warning input gives a `warn_irq` pulse exactly one cycle wide, visible after the third edge from the input change.
- R5: With bit 4 at 0, a warning onset produces no `warn_irq` pulse, but the flag is still set.
- R6: With the monitor on, `cpu_rst` is 1 from the second clock edge after the reset comparator input goes high.
- R7: `cpu_rst` falls exactly HOLD_CYCLES+3 edges after the reset comparator input returns low (the default for HOLD_CYCLES is 65,536). After `rst` is released with the input already low, it falls HOLD_CYCLES+1 edges later.
- R8: If the reset comparator input goes high again during the stabilisation count, the count restarts from zero once the input returns low.
- R9: `mon_en` is 0 only when `stop_mode` is 1 and the keep-reference bit (bit 5) is 0. `mon_lp` is 1 exactly when `stop_mode` is 1 and bit 5 is 1. Outside stop mode `mon_en` is 1 and `mon_lp` is 0.
- R10: While `mon_en` is 0, both comparator inputs are ignored: no flag is set, no interrupt is raised and no reset is asserted. The onset history is frozen, so a warning that was already present before the stop does not produce a new interrupt after it.
- R11: The power-on flag (bit 1) is set only by `rst` and is cleared by writing 1 to bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high cold start of the supervisor |
| cmp_warn_low | input | 1 | Asynchronous comparator: rail under the warning level |
| cmp_rst_low | input | 1 | Asynchronous comparator: rail under the reset level |
| stop_mode | input | 1 | Processor is in stop mode |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data: flags in bits 0 and 1, enables in bits 4 and 5 |
| cpu_rst | output | 1 | Internal processor reset |
| warn_irq | output | 1 | Power-warning interrupt request, one-cycle pulse |
| mon_en | output | 1 | Power enable for the reference and comparators |
| mon_lp | output | 1 | Low-consumption mode select for the reference and comparators |

## Verification
The comparator inputs pass through two synchroniser flops. As a result, the power-warning flag and the interrupt pulse show up after the third clock edge that follows a change on the warning input, and reset assertion shows up after the second edge that follows a change on the reset input. Reset release comes HOLD_CYCLES+3 edges after the reset input falls, or HOLD_CYCLES+1 edges after the cold start ends. The bench drives every input just after a falling clock edge, counts rising edges to the cycle where each result is due, and samples on the following falling edge. It also checks one edge earlier, to confirm that nothing arrives ahead of time. The stabilisation count is shortened to 32 in the bench so that the exact release edge can be checked several times.

// File: rtl/pwrsup_pkg.sv
package pwrsup_pkg;

    localparam int REG_W        = 8;
    localparam int BIT_PWARN    = 0;
    localparam int BIT_POR      = 1;
    localparam int BIT_IRQ_EN   = 4;
    localparam int BIT_KEEP_REF = 5;
    localparam int SYNC_STAGES  = 2;

    typedef enum logic [1:0] {
        HS_LOW  = 2'd0,
        HS_WAIT = 2'd1,
        HS_RUN  = 2'd2
    } hold_state_e;

    typedef struct packed {
        logic warn_low;
        logic rst_low;
    } cmp_pair_t;

    typedef struct packed {
        logic pwarn_flag;
        logic por_flag;
        logic irq_en;
        logic keep_ref;
    } ctl_regs_t;

    function automatic logic [REG_W-1:0] pack_regs(input ctl_regs_t r);
        logic [REG_W-1:0] v;
        v               = '0;
        v[BIT_PWARN]    = r.pwarn_flag;
        v[BIT_POR]      = r.por_flag;
        v[BIT_IRQ_EN]   = r.irq_en;
        v[BIT_KEEP_REF] = r.keep_ref;
        return v;
    endfunction

    function automatic logic onset(input logic now, input logic prev);
        return now & ~prev;
    endfunction

endpackage

// File: rtl/pwrsup_sync.sv
module pwrsup_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= '0;
                else     chain[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= '0;
                else     chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pwrsup_hold.sv
module pwrsup_hold
    import pwrsup_pkg::*;
#(
    parameter int HOLD_CYCLES = 65536
) (
    input  logic clk,
    input  logic rst,
    input  logic rst_low,
    output logic cpu_rst
);
    localparam int CW = (HOLD_CYCLES > 2) ? $clog2(HOLD_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

    hold_state_e state, state_nx;
    logic [CW-1:0] cnt, cnt_nx;

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        if (rst_low) begin
            state_nx = HS_LOW;
            cnt_nx   = '0;
        end else begin
            unique case (state)
                HS_LOW: begin
                    state_nx = HS_WAIT;
                    cnt_nx   = '0;
                end
                HS_WAIT: begin
                    if (cnt == LAST) state_nx = HS_RUN;
                    else             cnt_nx   = cnt + 1'b1;
                end
                HS_RUN:  state_nx = HS_RUN;
                default: state_nx = HS_LOW;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= HS_LOW;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // Assert straight from the synchronised comparator; release only from RUN.
    assign cpu_rst = (state != HS_RUN) | rst_low;
endmodule

// File: rtl/pwrsup_power.sv
module pwrsup_power (
    input  logic stop_mode,
    input  logic keep_ref,
    output logic mon_en,
    output logic mon_lp
);
    assign mon_en = ~stop_mode | keep_ref;
    assign mon_lp = stop_mode & keep_ref;
endmodule

// File: rtl/pwrsup_regfile.sv
module pwrsup_regfile
    import pwrsup_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             warn_low,
    input  logic             mon_en,
    input  logic             reg_we,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             warn_irq,
    output logic             keep_ref
);
    ctl_regs_t regs, regs_nx;
    logic      warn_hist;
    logic      irq_q;
    logic      rise;

    assign rise = onset(warn_low, warn_hist);

    always_comb begin
        regs_nx = regs;
        if (reg_we) begin
            regs_nx.irq_en   = reg_wdata[BIT_IRQ_EN];
            regs_nx.keep_ref = reg_wdata[BIT_KEEP_REF];
            if (reg_wdata[BIT_PWARN]) regs_nx.pwarn_flag = 1'b0;
            if (reg_wdata[BIT_POR])   regs_nx.por_flag   = 1'b0;
        end
        // The hardware set overrides a simultaneous software clear.
        if (warn_low) regs_nx.pwarn_flag = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs.pwarn_flag <= 1'b0;
            regs.por_flag   <= 1'b1;
            regs.irq_en     <= 1'b0;
            regs.keep_ref   <= 1'b0;
            warn_hist       <= 1'b0;
            irq_q           <= 1'b0;
        end else begin
            regs  <= regs_nx;
            irq_q <= rise & regs.irq_en;
            // The onset history stays frozen while the monitor is unpowered.
            if (mon_en) warn_hist <= warn_low;
        end
    end

    assign reg_rdata = pack_regs(regs);
    assign warn_irq  = irq_q;
    assign keep_ref  = regs.keep_ref;
endmodule

// File: rtl/pwrsup.sv
module pwrsup
    import pwrsup_pkg::*;
#(
    parameter int HOLD_CYCLES = 65536
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmp_warn_low,
    input  logic             cmp_rst_low,
    input  logic             stop_mode,
    input  logic             reg_we,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             cpu_rst,
    output logic             warn_irq,
    output logic             mon_en,
    output logic             mon_lp
);
    cmp_pair_t raw_cmp, sync_cmp, eff_cmp;
    logic      keep_ref;
    logic      warn_eff;
    logic      rst_low_eff;

    assign raw_cmp.warn_low = cmp_warn_low;
    assign raw_cmp.rst_low  = cmp_rst_low;

    pwrsup_sync #(
        .WIDTH  ($bits(cmp_pair_t)),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_cmp),
        .q   (sync_cmp)
    );

    pwrsup_power u_power (
        .stop_mode (stop_mode),
        .keep_ref  (keep_ref),
        .mon_en    (mon_en),
        .mon_lp    (mon_lp)
    );

    // An unpowered comparator says nothing.
    assign eff_cmp     = sync_cmp & {$bits(cmp_pair_t){mon_en}};
    assign warn_eff    = eff_cmp.warn_low;
    assign rst_low_eff = eff_cmp.rst_low;

    pwrsup_hold #(
        .HOLD_CYCLES (HOLD_CYCLES)
    ) u_hold (
        .clk     (clk),
        .rst     (rst),
        .rst_low (rst_low_eff),
        .cpu_rst (cpu_rst)
    );

    pwrsup_regfile u_regs (
        .clk       (clk),
        .rst       (rst),
        .warn_low  (warn_eff),
        .mon_en    (mon_en),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .warn_irq  (warn_irq),
        .keep_ref  (keep_ref)
    );
endmodule

// File: rtl/pwrsup_checker.sv
module pwrsup_checker (
    input logic       clk,
    input logic       rst,
    input logic       stop_mode,
    input logic       reg_we,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic       cpu_rst,
    input logic       warn_irq,
    input logic       mon_en,
    input logic       mon_lp,
    input logic       warn_eff,
    input logic       rst_low_eff
);
    a_r2_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[0] && !(reg_we && reg_wdata[0])) |=> reg_rdata[0]);

    a_r3_hw_set_wins: assert property (@(posedge clk) disable iff (rst)
        warn_eff |=> reg_rdata[0]);

    a_r4_irq_single: assert property (@(posedge clk) disable iff (rst)
        warn_irq |=> !warn_irq);

    a_r5_irq_gated: assert property (@(posedge clk) disable iff (rst)
        warn_irq |-> $past(reg_rdata[4]));

    a_r6_rst_on_low: assert property (@(posedge clk) disable iff (rst)
        rst_low_eff |-> cpu_rst);

    a_r7_release_clean: assert property (@(posedge clk) disable iff (rst)
        $fell(cpu_rst) |-> $past(!rst_low_eff));

    a_r9_lp_in_stop: assert property (@(posedge clk) disable iff (rst)
        mon_lp |-> (mon_en && stop_mode));

    a_r10_quiet_off: assert property (@(posedge clk) disable iff (rst)
        !mon_en |=> !warn_irq);

    a_r11_por_no_set: assert property (@(posedge clk) disable iff (rst)
        !reg_rdata[1] |=> !reg_rdata[1]);
endmodule

bind pwrsup pwrsup_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .stop_mode   (stop_mode),
    .reg_we      (reg_we),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .cpu_rst     (cpu_rst),
    .warn_irq    (warn_irq),
    .mon_en      (mon_en),
    .mon_lp      (mon_lp),
    .warn_eff    (warn_eff),
    .rst_low_eff (rst_low_eff)
);

// File: tb/pwrsup_bench.sv
module pwrsup_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 32;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst;
    logic       cmp_warn_low, cmp_rst_low, stop_mode, reg_we;
    logic [7:0] reg_wdata, reg_rdata;
    logic       cpu_rst, warn_irq, mon_en, mon_lp;

    int checks = 0;
    int fails  = 0;
    int irq_seen = 0;
    bit done = 0;

    pwrsup #(.HOLD_CYCLES(HOLD)) u_pwrsup (
        .clk          (clk),
        .rst          (rst),
        .cmp_warn_low (cmp_warn_low),
        .cmp_rst_low  (cmp_rst_low),
        .stop_mode    (stop_mode),
        .reg_we       (reg_we),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .cpu_rst      (cpu_rst),
        .warn_irq     (warn_irq),
        .mon_en       (mon_en),
        .mon_lp       (mon_lp)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) if (warn_irq) irq_seen++;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        reg_we = 1'b1; reg_wdata = d;
        tick(1);
        reg_we = 1'b0; reg_wdata = 8'h00;
    endtask

    task automatic t_reset;
        rst = 1'b1; cmp_warn_low = 0; cmp_rst_low = 0; stop_mode = 0;
        reg_we = 0; reg_wdata = 0;
        tick(3);
        chk("R1 cpu_rst", cpu_rst, 1);
        chk("R1 rdata", reg_rdata, 8'h02);
        chk("R1 irq", warn_irq, 0);
        chk("R1 mon_en", mon_en, 1);
        chk("R1 mon_lp", mon_lp, 0);
        rst = 1'b0;
        tick(HOLD);
        chk("R7 cold hold early", cpu_rst, 1);
        tick(1);
        chk("R7 cold release", cpu_rst, 0);
        wr(8'h02);
        chk("R11 por cleared", reg_rdata, 8'h00);
        tick(4);
        chk("R11 por stays clear", reg_rdata[1], 0);
    endtask

    task automatic t_warn_irq;
        int base;
        wr(8'h10);
        base = irq_seen;
        cmp_warn_low = 1;
        tick(2);
        chk("R2 flag not early", reg_rdata[0], 0);
        chk("R4 irq not early", warn_irq, 0);
        tick(1);
        chk("R2 flag set", reg_rdata[0], 1);
        chk("R4 irq pulse", warn_irq, 1);
        tick(1);
        chk("R4 irq one cycle", warn_irq, 0);
        cmp_warn_low = 0;
        tick(5);
        chk("R2 flag sticky", reg_rdata[0], 1);
        chk("R4 pulse count", irq_seen - base, 1);
        wr(8'h10);
        chk("R3 write 0 no effect", reg_rdata[0], 1);
        wr(8'h11);
        chk("R3 w1c clears", reg_rdata, 8'h10);
    endtask

    task automatic t_conflict;
        cmp_warn_low = 1;
        tick(4);
        wr(8'h11);
        chk("R3 hw set wins", reg_rdata[0], 1);
        cmp_warn_low = 0;
        tick(3);
        wr(8'h11);
        chk("R3 clear after release", reg_rdata[0], 0);
    endtask

    task automatic t_no_irq;
        int base;
        wr(8'h00);
        base = irq_seen;
        cmp_warn_low = 1;
        tick(6);
        chk("R5 no pulse", irq_seen - base, 0);
        chk("R5 flag still set", reg_rdata[0], 1);
        cmp_warn_low = 0;
        tick(3);
        wr(8'h01);
        chk("R5 cleared", reg_rdata[0], 0);
    endtask

    task automatic t_brownout;
        cmp_rst_low = 1;
        tick(1);
        chk("R6 not early", cpu_rst, 0);
        tick(1);
        chk("R6 reset asserted", cpu_rst, 1);
        tick(6);
        cmp_rst_low = 0;
        tick(HOLD + 2);
        chk("R7 hold early", cpu_rst, 1);
        tick(1);
        chk("R7 release", cpu_rst, 0);
    endtask

    task automatic t_restart;
        cmp_rst_low = 1;
        tick(4);
        cmp_rst_low = 0;
        tick(HOLD / 2);
        chk("R8 in hold", cpu_rst, 1);
        cmp_rst_low = 1;
        tick(4);
        cmp_rst_low = 0;
        tick(HOLD + 2);
        chk("R8 restarted count", cpu_rst, 1);
        tick(1);
        chk("R8 release after full count", cpu_rst, 0);
    endtask

    task automatic t_stop;
        int base;
        wr(8'h10);
        stop_mode = 1;
        tick(1);
        chk("R9 off in stop", mon_en, 0);
        chk("R9 lp off", mon_lp, 0);
        base = irq_seen;
        cmp_warn_low = 1; cmp_rst_low = 1;
        tick(6);
        chk("R10 no reset", cpu_rst, 0);
        chk("R10 no flag", reg_rdata[0], 0);
        chk("R10 no irq", irq_seen - base, 0);
        cmp_warn_low = 0; cmp_rst_low = 0;
        tick(3);
        stop_mode = 0;
        tick(4);
        chk("R9 on outside stop", mon_en, 1);
        chk("R10 quiet after stop", reg_rdata[0], 0);
        wr(8'h30);
        stop_mode = 1;
        tick(1);
        chk("R9 kept on", mon_en, 1);
        chk("R9 lp on", mon_lp, 1);
        cmp_warn_low = 1;
        tick(3);
        chk("R9 monitor live in lp", reg_rdata[0], 1);
        cmp_warn_low = 0;
        stop_mode = 0;
        tick(3);
        chk("R9 lp off out of stop", mon_lp, 0);
        wr(8'h11);
    endtask

    task automatic t_frozen;
        int base;
        cmp_warn_low = 1;
        tick(4);
        base = irq_seen;
        stop_mode = 1;
        tick(3);
        stop_mode = 0;
        tick(5);
        chk("R10 history frozen", irq_seen - base, 0);
        cmp_warn_low = 0;
        tick(3);
        wr(8'h01);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_warn_irq();
        t_conflict();
        t_no_irq();
        t_brownout();
        t_restart();
        t_stop();
        t_frozen();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule